// File: doc/BRIEF.md
# Cascaded Divisor Pair Search Engine

The block picks two divisors for a pair of cascaded counters so that their product, multiplied by an oscillator base period, comes as close as possible to a requested period. A one-cycle `start` pulse captures the requested period, the base period, a 2-bit rounding mode and a pair of suggested divisor codes. After a multi-cycle search, a one-cycle `done` pulse presents two counter codes and the period that those codes actually produce.

The engine first tests the suggested pair. If that pair already yields the request exactly, and no product overflows, the pair is handed back unchanged. Otherwise the engine sets a target total division. It then walks outer divisors upward and, for each outer divisor, a short run of inner divisors. It looks at no more than one candidate per clock. Each quotient comes from a shared iterative restoring divider.

Two candidates are tracked during the walk: the best one not above the request and the best one not below it. The rounding mode chooses between them at the end. All arithmetic is 32-bit unsigned and wraps. The base period must be nonzero.

Top module: `cascade_div_search`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `d1_out`, `d2_out` and `ns_out` are 0.
- R2: A `start` pulse while `busy` is 0 makes `busy` 1 in the next cycle. A `start` pulse while `busy` is 1 is ignored and leaves the running search's result unchanged.
- R3: A suggested code of 0 stands for 65536. The suggested pair is returned unchanged, with `ns_out` equal to the request, only if all of these hold: both divisors are greater than 1; divisor1*divisor2*base equals the request; the divisor product is greater than each divisor; and product*base is greater than both the product and the base.
- R4: In every other case the target is request/base, truncated. Outer divisor a starts at max(target/65536, 2) and continues while a <= target/a + 1 and a <= 65536. For each a, inner divisor b starts at target/a and continues while a*b <= target + a + 1 and b <= 65536.
- R5: The lower candidate is the first pair reaching the largest period base*a*b that is at most the request. The upper candidate is the first pair reaching the smallest period that is at least the request. Both start as divisors 0/0.
- R6: Mode 1 (up) returns the upper candidate.
- R7: Mode 2 (down) returns the lower candidate, so `ns_out` never exceeds the request.
- R8: Modes 0 and 3 (nearest) return the upper candidate only when (upper period - request) < (request - lower period) in wrapping 32-bit arithmetic. A tie goes to the lower candidate.
- R9: `ns_out` equals code1*code2*base modulo 2^32, with each divisor taken before masking. Each code is its divisor's low 16 bits, so 65536 is output as 0.
- R10: `done` lasts exactly one cycle and rises in the same cycle that `busy` falls. The outputs change only when `done` is high.
- R11: When the search finds no candidate, for example a target of 1, the outputs are 0, 0 and 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, taken only when idle |
| req_ns | input | 32 | Requested period |
| base_ns | input | 32 | Oscillator base period, nonzero |
| mode | input | 2 | 0 nearest, 1 up, 2 down, 3 nearest |
| d1_in | input | 16 | Suggested first divisor code (0 = 65536) |
| d2_in | input | 16 | Suggested second divisor code (0 = 65536) |
| busy | output | 1 | High while a search or pass-through is in progress |
| done | output | 1 | One-cycle result strobe |
| d1_out | output | 16 | First divisor code |
| d2_out | output | 16 | Second divisor code |
| ns_out | output | 32 | Period achieved by the returned codes |

## Verification
The assertions check on every cycle that `done` is a single-cycle pulse that follows `busy`, that `busy` and `done` are never high together, that an idle start raises `busy`, that the outputs hold steady between results, and that round-down results never exceed the request. The choice of candidate, the exact-pair pass-through, the tie rule in nearest mode, and the case where no candidate exists all depend on the whole search sequence. Only the bench's directed and random scenarios can show these, by comparing against a model of the same search.

// File: rtl/cascade_div_search.sv
module cascade_div_search #(
  parameter int W  = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  req_ns,
  input  logic [W-1:0]  base_ns,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] d1_in,
  input  logic [CW-1:0] d2_in,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] d1_out,
  output logic [CW-1:0] d2_out,
  output logic [W-1:0]  ns_out
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] TWO  = ONE << 1;
  localparam logic [W-1:0] MAXC = ONE << CW;
  localparam int           CNTW = $clog2(W) + 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);

  typedef enum logic [2:0] {S_IDLE, S_EXACT, S_TGT, S_Q, S_IN, S_PICK} st_t;
  st_t st;

  logic [W-1:0]  req_q, base_q, tgt, div1, div2;
  logic [1:0]    mode_q;
  logic [CW-1:0] c1_q, c2_q;
  logic [W-1:0]  lo_ns, lo_a, lo_b, hi_ns, hi_a, hi_b;

  logic [W-1:0]    dv_n, dv_d;
  logic [W:0]      dv_r;
  logic [CNTW-1:0] dv_cnt;
  logic            dv_run;

  // one restoring-divider step
  logic [W:0]   r_sh;
  logic         r_ge;
  assign r_sh = {dv_r[W-1:0], dv_n[W-1]};
  assign r_ge = r_sh >= {1'b0, dv_d};

  // pass-through test on the incoming pair
  logic [W-1:0] e1, e2, eprod, etot;
  logic         exact;
  assign e1    = (d1_in == '0) ? MAXC : {{(W-CW){1'b0}}, d1_in};
  assign e2    = (d2_in == '0) ? MAXC : {{(W-CW){1'b0}}, d2_in};
  assign eprod = e1 * e2;
  assign etot  = eprod * base_ns;
  assign exact = (etot == req_ns) && (e1 > ONE) && (e1 <= MAXC) &&
                 (e2 > ONE) && (e2 <= MAXC) && (eprod > e1) && (eprod > e2) &&
                 (etot > eprod) && (etot > base_ns);

  // search arithmetic
  logic [W-1:0] first_a, p12, cand, lim;
  assign first_a = ((dv_n >> CW) < TWO) ? TWO : (dv_n >> CW);
  assign p12     = div1 * div2;
  assign cand    = base_q * p12;
  assign lim     = tgt + div1 + ONE;

  // final selection
  logic [W-1:0] hi_p, lo_p, sel_a, sel_b;
  logic         take_hi;
  assign hi_p = hi_a * hi_b * base_q;
  assign lo_p = lo_a * lo_b * base_q;
  always_comb begin
    case (mode_q)
      2'd1:    take_hi = 1'b1;
      2'd2:    take_hi = 1'b0;
      default: take_hi = (hi_p - req_q) < (req_q - lo_p);
    endcase
  end
  assign sel_a = take_hi ? hi_a : lo_a;
  assign sel_b = take_hi ? hi_b : lo_b;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      d1_out <= '0;
      d2_out <= '0;
      ns_out <= '0;
      req_q  <= '0;
      base_q <= '0;
      mode_q <= '0;
      c1_q   <= '0;
      c2_q   <= '0;
      tgt    <= '0;
      div1   <= '0;
      div2   <= '0;
      lo_ns  <= '0;
      lo_a   <= '0;
      lo_b   <= '0;
      hi_ns  <= '1;
      hi_a   <= '0;
      hi_b   <= '0;
      dv_n   <= '0;
      dv_d   <= '0;
      dv_r   <= '0;
      dv_cnt <= '0;
      dv_run <= 1'b0;
    end else begin
      done <= 1'b0;
      if (dv_run) begin
        dv_r   <= r_ge ? (r_sh - {1'b0, dv_d}) : r_sh;
        dv_n   <= {dv_n[W-2:0], r_ge};
        dv_cnt <= dv_cnt + 1'b1;
        if (dv_cnt == LAST) dv_run <= 1'b0;
      end
      case (st)
        S_IDLE: if (start) begin
          req_q  <= req_ns;
          base_q <= base_ns;
          mode_q <= mode;
          c1_q   <= d1_in;
          c2_q   <= d2_in;
          if (exact) st <= S_EXACT;
          else begin
            dv_n <= req_ns; dv_d <= base_ns; dv_r <= '0;
            dv_cnt <= '0; dv_run <= 1'b1;
            st <= S_TGT;
          end
        end
        S_EXACT: begin
          d1_out <= c1_q;
          d2_out <= c2_q;
          ns_out <= req_q;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        S_TGT: if (!dv_run) begin
          tgt   <= dv_n;
          div1  <= first_a;
          lo_ns <= '0; lo_a <= '0; lo_b <= '0;
          hi_ns <= '1; hi_a <= '0; hi_b <= '0;
          dv_d <= first_a; dv_r <= '0; dv_cnt <= '0; dv_run <= 1'b1;
          st <= S_Q;
        end
        S_Q: if (!dv_run) begin
          if ((div1 <= dv_n + ONE) && (div1 <= MAXC)) begin
            div2 <= dv_n;
            st   <= S_IN;
          end else st <= S_PICK;
        end
        S_IN: begin
          if ((p12 <= lim) && (div2 <= MAXC)) begin
            if ((cand <= req_q) && (cand > lo_ns)) begin
              lo_ns <= cand; lo_a <= div1; lo_b <= div2;
            end
            if ((cand >= req_q) && (cand < hi_ns)) begin
              hi_ns <= cand; hi_a <= div1; hi_b <= div2;
            end
            div2 <= div2 + ONE;
          end else begin
            div1 <= div1 + ONE;
            dv_n <= tgt; dv_d <= div1 + ONE; dv_r <= '0;
            dv_cnt <= '0; dv_run <= 1'b1;
            st <= S_Q;
          end
        end
        S_PICK: begin
          d1_out <= sel_a[CW-1:0];
          d2_out <= sel_b[CW-1:0];
          ns_out <= sel_a * sel_b * base_q;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module cascade_div_search_chk #(
  parameter int W  = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [1:0]    mode_q,
  input logic [W-1:0]  req_q,
  input logic [W-1:0]  ns_out,
  input logic [CW-1:0] d1_out,
  input logic [CW-1:0] d2_out
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  // R10
  outputs_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(ns_out) && $stable(d1_out) && $stable(d2_out)));
  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R7
  round_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == 2'd2) |-> (ns_out <= req_q));
endmodule

bind cascade_div_search cascade_div_search_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mode_q(mode_q), .req_q(req_q), .ns_out(ns_out),
  .d1_out(d1_out), .d2_out(d2_out)
);

// File: tb/cascade_div_search_test.sv
module cascade_div_search_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] req_ns = '0, base_ns = 32'd1;
  logic [1:0]  mode = '0;
  logic [15:0] d1_in = '0, d2_in = '0;
  logic busy, done;
  logic [15:0] d1_out, d2_out;
  logic [31:0] ns_out;
  int n_run = 0, n_fail = 0;
  int unsigned cyc = 0;
  bit finished = 0;

  cascade_div_search uut (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input int unsigned req, input int unsigned base, input logic [1:0] md,
                       input logic [15:0] c1, input logic [15:0] c2,
                       output logic [15:0] o1, output logic [15:0] o2, output int unsigned ons);
    int unsigned e1, e2, pr, tg, st, la, lb, ha, hb, lns, hns, cns, hp, lp, sa, sb;
    bit hi;
    e1 = (c1 == 0) ? 32'h10000 : c1;
    e2 = (c2 == 0) ? 32'h10000 : c2;
    pr = e1 * e2;
    if (pr * base == req && e1 > 1 && e2 > 1 && pr > e1 && pr > e2 &&
        pr * base > pr && pr * base > base) begin
      o1 = c1; o2 = c2; ons = req; return;
    end
    tg = req / base;
    st = tg / 32'h10000; if (st < 2) st = 2;
    la = 0; lb = 0; ha = 0; hb = 0; lns = 0; hns = 32'hffffffff;
    for (int unsigned a = st; a <= tg / a + 1 && a <= 32'h10000; a++)
      for (int unsigned b = tg / a; a * b <= tg + a + 1 && b <= 32'h10000; b++) begin
        cns = base * a * b;
        if (cns <= req && cns > lns) begin lns = cns; la = a; lb = b; end
        if (cns >= req && cns < hns) begin hns = cns; ha = a; hb = b; end
      end
    hp = ha * hb * base; lp = la * lb * base;
    if (md == 2'd1) hi = 1;
    else if (md == 2'd2) hi = 0;
    else hi = (hp - req) < (req - lp);
    sa = hi ? ha : la; sb = hi ? hb : lb;
    o1 = sa[15:0]; o2 = sb[15:0]; ons = sa * sb * base;
  endtask

  task automatic launch(input int unsigned req, input int unsigned base, input logic [1:0] md,
                        input logic [15:0] c1, input logic [15:0] c2);
    @(negedge clk);
    req_ns = req; base_ns = base; mode = md; d1_in = c1; d2_in = c2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 40000) begin @(negedge clk); n++; end
    chk(done, "R10 done timeout", n, 0);
    chk(!busy, "R10 busy low at done", busy, 0);
  endtask

  task automatic run(input int unsigned req, input int unsigned base, input logic [1:0] md,
                     input logic [15:0] c1, input logic [15:0] c2, input string tag);
    logic [15:0] x1, x2; int unsigned xn;
    model(req, base, md, c1, c2, x1, x2, xn);
    launch(req, base, md, c1, c2);
    chk(busy, "R2 busy after start", busy, 1);
    wait_done();
    chk(d1_out == x1, {tag, " d1"}, d1_out, x1);
    chk(d2_out == x2, {tag, " d2"}, d2_out, x2);
    chk(ns_out == xn, {tag, " ns"}, ns_out, xn);
  endtask

  initial begin
    while (!finished && cyc < 190000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] x1, x2; int unsigned xn;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy && !done, "R1 flags", {busy, done}, 0);
    chk(d1_out == 0 && d2_out == 0 && ns_out == 0, "R1 outputs", ns_out, 0);

    // R3 exact pair, and code 0 as 65536
    run(10000, 50, 2'd0, 16'd10, 16'd20, "R3 exact");
    chk(d1_out == 10 && d2_out == 20 && ns_out == 10000, "R3 exact fixed", ns_out, 10000);
    run(393216, 3, 2'd2, 16'd0, 16'd2, "R3 code0");
    chk(d1_out == 0 && d2_out == 2 && ns_out == 393216, "R3 code0 fixed", ns_out, 393216);

    // R8 tie to lower, R6 up, R7 down, mode 3 as nearest; R4 R5 search order
    run(101, 1, 2'd0, 16'd0, 16'd0, "R8 tie");
    chk(d1_out == 2 && d2_out == 50 && ns_out == 100, "R8 tie lower", ns_out, 100);
    run(101, 1, 2'd3, 16'd0, 16'd0, "R8 mode3");
    chk(ns_out == 100, "R8 mode3 nearest", ns_out, 100);
    run(101, 1, 2'd1, 16'd0, 16'd0, "R6 up");
    chk(d1_out == 2 && d2_out == 51 && ns_out == 102, "R6 up fixed", ns_out, 102);
    run(101, 1, 2'd2, 16'd0, 16'd0, "R7 down");
    chk(d1_out == 2 && d2_out == 50 && ns_out == 100, "R7 down fixed", ns_out, 100);
    run(2000, 1, 2'd0, 16'd3, 16'd3, "R4 R5 R9 search");

    // R11 no candidate
    run(1500, 1000, 2'd1, 16'd0, 16'd0, "R11 none");
    chk(d1_out == 0 && d2_out == 0 && ns_out == 0, "R11 zeros", ns_out, 0);

    // R2 start while busy ignored
    model(7777, 3, 2'd0, 16'd0, 16'd0, x1, x2, xn);
    launch(7777, 3, 2'd0, 16'd0, 16'd0);
    repeat (5) @(negedge clk);
    req_ns = 500; base_ns = 7; mode = 2'd1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    chk(d1_out == x1 && d2_out == x2 && ns_out == xn, "R2 ignored start", ns_out, xn);
    // R10 outputs held
    repeat (4) @(negedge clk);
    chk(!done && ns_out == xn && d1_out == x1, "R10 held", ns_out, xn);

    // random mix, R9 checked against model
    for (int i = 0; i < 36; i++) begin
      int unsigned b, t, r; logic [15:0] c1, c2;
      b = 1 + $urandom % 100;
      t = 4 + $urandom % 3000;
      r = b * t + $urandom % b;
      c1 = $urandom; c2 = $urandom;
      if (i % 4 == 0) begin
        c1 = 2 + $urandom % 50; c2 = 2 + $urandom % 50; r = c1 * c2 * b;
      end
      run(r, b, 2'($urandom), c1, c2, "R9 random");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule